// File: doc/BRIEF.md
# I2C FIFO and Event Status Unit

This unit sits between a processor-facing register front end and the protocol engine of an I2C master. It holds two byte queues: a transmit queue filled by software and drained by the engine, and a receive queue filled by the engine and drained by software. Both queues report level flags that depend on programmable thresholds. Each queue also has a flush sequence that runs for several cycles and clears the queue when it ends.

The unit also keeps the controller's event status. The queue level flags follow the queue state directly. Pulse events from the transaction logic, and the transmit overrun condition, set sticky bits that software resets by writing ones to a clear strobe. A mask register selects which raw bits reach the masked status word, and the interrupt line is the OR of that masked word.

Both byte streams use valid/ready. A byte moves on a cycle where valid and ready are both high. Each write port drops ready while its queue is full or while that queue is flushing. Each read port drops valid while its queue is empty or flushing. The transmit writer stands for software and may ignore ready. A transmit byte offered while the queue is full and not flushing is dropped and raises an overrun. A byte offered while its queue is flushing is dropped and raises nothing.

Top module: `i2cfs_top`

## Requirements
- R1: After reset both queues are empty, no flush is running, the mask register reads 0, the interrupt is low, and no sticky bit is set.
- R2: Each queue returns bytes in the order they were accepted. A byte is accepted only when valid and ready are both high. Write ready is low when the queue holds DEPTH (16) bytes or is flushing.
- R3: Raw bit 0 reports that the transmit queue is empty and raw bit 2 that it is full. Raw bit 4 reports that the receive queue is empty and raw bit 6 that it is full. Each flag follows the queue occupancy in the cycle after the change.
- R4: Raw bit 1 (transmit nearly empty) is 1 while the transmit occupancy is at or below the transmit threshold (0 to 15).
- R5: Raw bit 5 (receive nearly full) is 1 while the receive occupancy is at or above the receive threshold (0 to 15).
- R6: Offering a transmit byte while the transmit queue is full and not flushing drops the byte and sets sticky raw bit 3 in the next cycle.
- R7: A pulse on evt_pulse bits 16 to 20, 24, 25 or 28 sets the sticky raw bit at the same position in the next cycle. evt_pulse bits at any other position have no effect on the raw status.
- R8: Writing clr_wdata with clr_wr resets each sticky bit whose position holds a 1, within 0x131F007F. A set pulse in the same cycle wins over the clear. Level flags and bits outside that mask are unaffected.
- R9: A mask write stores mask_wdata with bits 31:29 forced to 0. The masked status equals the raw status AND the mask, and irq is 1 exactly when the masked status is nonzero.
- R10: A flush request starts FLUSH_CYCLES (4) busy cycles. While busy, the queue neither accepts nor delivers bytes. When busy falls, the queue is empty. A request made while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_wr_valid | input | 1 | Software offers a transmit byte |
| tx_wr_ready | output | 1 | Transmit queue can accept a byte |
| tx_wr_data | input | 8 | Transmit byte from software |
| tx_rd_valid | output | 1 | Transmit byte available to the engine |
| tx_rd_ready | input | 1 | Engine takes the transmit byte |
| tx_rd_data | output | 8 | Oldest transmit byte |
| rx_wr_valid | input | 1 | Engine offers a received byte |
| rx_wr_ready | output | 1 | Receive queue can accept a byte |
| rx_wr_data | input | 8 | Received byte from the engine |
| rx_rd_valid | output | 1 | Received byte available to software |
| rx_rd_ready | input | 1 | Software takes the received byte |
| rx_rd_data | output | 8 | Oldest received byte |
| tx_thr | input | 4 | Transmit nearly-empty threshold |
| rx_thr | input | 4 | Receive nearly-full threshold |
| flush_tx_req | input | 1 | Start a transmit queue flush |
| flush_rx_req | input | 1 | Start a receive queue flush |
| flush_tx_busy | output | 1 | Transmit flush in progress |
| flush_rx_busy | output | 1 | Receive flush in progress |
| evt_pulse | input | 32 | One-cycle event pulses from the transaction logic |
| clr_wr | input | 1 | Clear register write strobe |
| clr_wdata | input | 32 | Write-one-to-clear data |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | 32 | Mask register write data |
| mask_rd | output | 32 | Current mask register value |
| raw_status | output | 32 | Raw event and level status |
| masked_status | output | 32 | Raw status AND mask |
| irq | output | 1 | Interrupt line |

## Verification
The hardest states to reach are the collisions. One is a byte offered on the very cycle a flush ends. Others are a full transmit queue that is still offered bytes while the engine pops, and a sticky set arriving in the same cycle as its clear. Directed phases set up each of these on purpose: one fills the queue to 16 and keeps offering bytes, one issues a flush and then a second request inside the busy window, and one pulses an event together with a clear of the same bit. A long random phase follows, with frequent short flushes and threshold changes. A behavioural model built on queues is compared with every output on every cycle.

// File: rtl/i2cfs_pkg.sv
package i2cfs_pkg;
  localparam int ST_W = 32;
  localparam int B_TX_EMPTY = 0;
  localparam int B_TX_NEAR  = 1;
  localparam int B_TX_FULL  = 2;
  localparam int B_TX_OVR   = 3;
  localparam int B_RX_EMPTY = 4;
  localparam int B_RX_NEAR  = 5;
  localparam int B_RX_FULL  = 6;
  localparam logic [ST_W-1:0] EXT_EVT_BITS = 32'h131F_0000;
  localparam logic [ST_W-1:0] CLR_BITS     = 32'h131F_007F;
  localparam logic [ST_W-1:0] STICKY_BITS  = EXT_EVT_BITS | (32'h1 << B_TX_OVR);
  localparam logic [ST_W-1:0] MASK_BITS    = 32'h1FFF_FFFF;

  typedef struct packed {
    logic full;
    logic near;
    logic empty;
  } lvl_t;
endpackage

// File: rtl/i2cfs_fifo.sv
module i2cfs_fifo
  import i2cfs_pkg::*;
#(
  parameter int W            = 8,
  parameter int DEPTH        = 16,
  parameter int THR_W        = 4,
  parameter int FLUSH_CYCLES = 4,
  parameter bit NEAR_BELOW   = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_data,
  input  logic [THR_W-1:0] thr,
  input  logic             flush_req,
  output logic             flush_busy,
  output logic             overrun,
  output lvl_t             flags
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int FW = $clog2(FLUSH_CYCLES + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic [FW-1:0] fcnt;
  logic          busy;
  logic          push, pop, full;

  assign full      = (cnt == CW'(DEPTH));
  assign in_ready  = !full && !busy;
  assign out_valid = (cnt != '0) && !busy;
  assign out_data  = mem[rptr];
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;
  assign overrun   = in_valid && full && !busy;
  assign flush_busy = busy;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      fcnt <= '0;
      busy <= 1'b0;
    end else if (busy) begin
      if (fcnt == '0) begin
        busy <= 1'b0;
        wptr <= '0;
        rptr <= '0;
        cnt  <= '0;
      end else begin
        fcnt <= fcnt - 1'b1;
      end
    end else begin
      if (flush_req) begin
        busy <= 1'b1;
        fcnt <= FW'(FLUSH_CYCLES - 1);
      end
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  assign flags.empty = (cnt == '0);
  assign flags.full  = full;
  generate
    if (NEAR_BELOW) begin : g_near_le
      assign flags.near = (cnt <= CW'(thr));
    end else begin : g_near_ge
      assign flags.near = (cnt >= CW'(thr));
    end
  endgenerate
endmodule

// File: rtl/i2cfs_evt_regs.sv
module i2cfs_evt_regs
  import i2cfs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] level,
  input  logic [ST_W-1:0] set_pulse,
  input  logic            clr_wr,
  input  logic [ST_W-1:0] clr_wdata,
  input  logic            mask_wr,
  input  logic [ST_W-1:0] mask_wdata,
  output logic [ST_W-1:0] raw,
  output logic [ST_W-1:0] masked,
  output logic [ST_W-1:0] mask_q,
  output logic            irq
);
  logic [ST_W-1:0] sticky;
  logic [ST_W-1:0] clr_eff;

  assign clr_eff = clr_wr ? (clr_wdata & CLR_BITS) : '0;

  generate
    for (genvar i = 0; i < ST_W; i++) begin : g_bit
      if (STICKY_BITS[i]) begin : g_sticky
        always_ff @(posedge clk) begin
          if (!rst_n) sticky[i] <= 1'b0;
          else        sticky[i] <= set_pulse[i] | (sticky[i] & ~clr_eff[i]);
        end
      end else begin : g_none
        assign sticky[i] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= mask_wdata & MASK_BITS;
  end

  assign raw    = sticky | (level & ~STICKY_BITS);
  assign masked = raw & mask_q;
  assign irq    = |masked;
endmodule

// File: rtl/i2cfs_top.sv
module i2cfs_top
  import i2cfs_pkg::*;
#(
  parameter int W            = 8,
  parameter int DEPTH        = 16,
  parameter int THR_W        = 4,
  parameter int FLUSH_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_wr_valid,
  output logic             tx_wr_ready,
  input  logic [W-1:0]     tx_wr_data,
  output logic             tx_rd_valid,
  input  logic             tx_rd_ready,
  output logic [W-1:0]     tx_rd_data,
  input  logic             rx_wr_valid,
  output logic             rx_wr_ready,
  input  logic [W-1:0]     rx_wr_data,
  output logic             rx_rd_valid,
  input  logic             rx_rd_ready,
  output logic [W-1:0]     rx_rd_data,
  input  logic [THR_W-1:0] tx_thr,
  input  logic [THR_W-1:0] rx_thr,
  input  logic             flush_tx_req,
  input  logic             flush_rx_req,
  output logic             flush_tx_busy,
  output logic             flush_rx_busy,
  input  logic [31:0]      evt_pulse,
  input  logic             clr_wr,
  input  logic [31:0]      clr_wdata,
  input  logic             mask_wr,
  input  logic [31:0]      mask_wdata,
  output logic [31:0]      mask_rd,
  output logic [31:0]      raw_status,
  output logic [31:0]      masked_status,
  output logic             irq
);
  lvl_t            tx_flags, rx_flags;
  logic            tx_ovr, rx_ovr_unused;
  logic [ST_W-1:0] level_vec, set_vec;

  i2cfs_fifo #(.W(W), .DEPTH(DEPTH), .THR_W(THR_W),
               .FLUSH_CYCLES(FLUSH_CYCLES), .NEAR_BELOW(1'b1)) u_txq (
    .clk, .rst_n,
    .in_valid(tx_wr_valid), .in_ready(tx_wr_ready), .in_data(tx_wr_data),
    .out_valid(tx_rd_valid), .out_ready(tx_rd_ready), .out_data(tx_rd_data),
    .thr(tx_thr), .flush_req(flush_tx_req), .flush_busy(flush_tx_busy),
    .overrun(tx_ovr), .flags(tx_flags)
  );

  i2cfs_fifo #(.W(W), .DEPTH(DEPTH), .THR_W(THR_W),
               .FLUSH_CYCLES(FLUSH_CYCLES), .NEAR_BELOW(1'b0)) u_rxq (
    .clk, .rst_n,
    .in_valid(rx_wr_valid), .in_ready(rx_wr_ready), .in_data(rx_wr_data),
    .out_valid(rx_rd_valid), .out_ready(rx_rd_ready), .out_data(rx_rd_data),
    .thr(rx_thr), .flush_req(flush_rx_req), .flush_busy(flush_rx_busy),
    .overrun(rx_ovr_unused), .flags(rx_flags)
  );

  always_comb begin
    level_vec             = '0;
    level_vec[B_TX_EMPTY] = tx_flags.empty;
    level_vec[B_TX_NEAR]  = tx_flags.near;
    level_vec[B_TX_FULL]  = tx_flags.full;
    level_vec[B_RX_EMPTY] = rx_flags.empty;
    level_vec[B_RX_NEAR]  = rx_flags.near;
    level_vec[B_RX_FULL]  = rx_flags.full;
    set_vec               = evt_pulse & EXT_EVT_BITS;
    set_vec[B_TX_OVR]     = tx_ovr;
  end

  i2cfs_evt_regs u_evt (
    .clk, .rst_n,
    .level(level_vec), .set_pulse(set_vec),
    .clr_wr, .clr_wdata, .mask_wr, .mask_wdata,
    .raw(raw_status), .masked(masked_status), .mask_q(mask_rd), .irq
  );
endmodule

// File: rtl/i2cfs_chk.sv
module i2cfs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_wr_valid,
  input logic        tx_wr_ready,
  input logic        tx_rd_valid,
  input logic        rx_wr_ready,
  input logic        rx_rd_valid,
  input logic        flush_tx_busy,
  input logic        flush_rx_busy,
  input logic [31:0] evt_pulse,
  input logic        clr_wr,
  input logic [31:0] clr_wdata,
  input logic [31:0] mask_rd,
  input logic [31:0] raw_status,
  input logic [31:0] masked_status,
  input logic        irq
);
  AST_FULL_BLOCKS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    raw_status[2] |-> !tx_wr_ready); // R2
  AST_EMPTY_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    raw_status[0] |-> !tx_rd_valid); // R3
  AST_OVERRUN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr_valid && raw_status[2] && !flush_tx_busy) |=> raw_status[3]); // R6
  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse[25] |=> raw_status[25]); // R7
  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_status[24] && !(clr_wr && clr_wdata[24])) |=> raw_status[24]); // R8
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_wdata[19] && !evt_pulse[19]) |=> !raw_status[19]); // R8
  AST_MASKED_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (masked_status & ~raw_status) == 32'h0); // R9
  AST_IRQ_FROM_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (masked_status != 32'h0)); // R9
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mask_rd[31:29] == 3'b000); // R9
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flush_tx_busy) |-> raw_status[0]); // R10
  AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    flush_rx_busy |-> (!rx_rd_valid && !rx_wr_ready)); // R10
endmodule

bind i2cfs_top i2cfs_chk u_chk (.*);

// File: tb/tb_i2cfs_top.sv
`timescale 1ns/1ps
module tb_i2cfs_top;
  localparam int DEPTH = 16;
  localparam int FLUSH_CYCLES = 4;
  localparam logic [31:0] EXT_EVT = 32'h131F_0000;
  localparam logic [31:0] CLRM    = 32'h131F_0008;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_wr_valid = 0, tx_rd_ready = 0, rx_wr_valid = 0, rx_rd_ready = 0;
  logic [7:0] tx_wr_data = 0, rx_wr_data = 0;
  logic [3:0] tx_thr = 4'd3, rx_thr = 4'd4;
  logic flush_tx_req = 0, flush_rx_req = 0, clr_wr = 0, mask_wr = 0;
  logic [31:0] evt_pulse = 0, clr_wdata = 0, mask_wdata = 0;
  logic tx_wr_ready, tx_rd_valid, rx_wr_ready, rx_rd_valid, flush_tx_busy, flush_rx_busy, irq;
  logic [7:0] tx_rd_data, rx_rd_data;
  logic [31:0] mask_rd, raw_status, masked_status;

  always #2.5 clk = ~clk;

  i2cfs_top dut (.*);

  int n_tests = 0, n_fail = 0;

  // behavioural reference
  logic [7:0] q_tx[$], q_rx[$];
  bit tx_busy_m, rx_busy_m;
  int tx_fc, rx_fc;
  logic [31:0] sticky_m, mask_m;

  always @(posedge clk) begin
    if (!rst_n) begin
      q_tx.delete(); q_rx.delete();
      tx_busy_m = 0; rx_busy_m = 0; tx_fc = 0; rx_fc = 0;
      sticky_m = 0; mask_m = 0;
    end else begin
      bit tpush, tpop, rpush, rpop, ovr;
      logic [31:0] setv, clrv;
      tpush = tx_wr_valid && q_tx.size() < DEPTH && !tx_busy_m;
      tpop  = tx_rd_ready && q_tx.size() > 0 && !tx_busy_m;
      ovr   = tx_wr_valid && q_tx.size() == DEPTH && !tx_busy_m;
      rpush = rx_wr_valid && q_rx.size() < DEPTH && !rx_busy_m;
      rpop  = rx_rd_ready && q_rx.size() > 0 && !rx_busy_m;
      if (tpop) void'(q_tx.pop_front());
      if (tpush) q_tx.push_back(tx_wr_data);
      if (rpop) void'(q_rx.pop_front());
      if (rpush) q_rx.push_back(rx_wr_data);
      if (tx_busy_m) begin
        if (tx_fc == 0) begin tx_busy_m = 0; q_tx.delete(); end else tx_fc--;
      end else if (flush_tx_req) begin tx_busy_m = 1; tx_fc = FLUSH_CYCLES - 1; end
      if (rx_busy_m) begin
        if (rx_fc == 0) begin rx_busy_m = 0; q_rx.delete(); end else rx_fc--;
      end else if (flush_rx_req) begin rx_busy_m = 1; rx_fc = FLUSH_CYCLES - 1; end
      setv = (evt_pulse & EXT_EVT) | (ovr ? 32'h8 : 32'h0);
      clrv = clr_wr ? (clr_wdata & CLRM) : 32'h0;
      sticky_m = setv | (sticky_m & ~clrv);
      if (mask_wr) mask_m = mask_wdata & 32'h1FFF_FFFF;
    end
  end

  function automatic logic [31:0] exp_raw();
    logic [31:0] r;
    r = sticky_m;
    r[0] = (q_tx.size() == 0);
    r[1] = (q_tx.size() <= int'(tx_thr));
    r[2] = (q_tx.size() == DEPTH);
    r[4] = (q_rx.size() == 0);
    r[5] = (q_rx.size() >= int'(rx_thr));
    r[6] = (q_rx.size() == DEPTH);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  task automatic check_all();
    logic [31:0] er;
    er = exp_raw();
    chk("R2 tx_wr_ready", 32'(tx_wr_ready), 32'(q_tx.size() < DEPTH && !tx_busy_m));
    chk("R2 rx_wr_ready", 32'(rx_wr_ready), 32'(q_rx.size() < DEPTH && !rx_busy_m));
    chk("R2 tx_rd_valid", 32'(tx_rd_valid), 32'(q_tx.size() > 0 && !tx_busy_m));
    chk("R2 rx_rd_valid", 32'(rx_rd_valid), 32'(q_rx.size() > 0 && !rx_busy_m));
    if (q_tx.size() > 0 && !tx_busy_m) chk("R2 tx_rd_data", 32'(tx_rd_data), 32'(q_tx[0]));
    if (q_rx.size() > 0 && !rx_busy_m) chk("R2 rx_rd_data", 32'(rx_rd_data), 32'(q_rx[0]));
    chk("R3 empty/full flags", raw_status & 32'h55, er & 32'h55);
    chk("R4 tx nearly empty", 32'(raw_status[1]), 32'(er[1]));
    chk("R5 rx nearly full", 32'(raw_status[5]), 32'(er[5]));
    chk("R6 overrun", 32'(raw_status[3]), 32'(er[3]));
    chk("R7 R8 event bits", raw_status & ~32'h7F, er & ~32'h7F);
    chk("R9 mask_rd", mask_rd, mask_m);
    chk("R9 masked", masked_status, er & mask_m);
    chk("R9 irq", 32'(irq), 32'((er & mask_m) != 0));
    chk("R10 flush busy", {30'b0, flush_rx_busy, flush_tx_busy}, {30'b0, rx_busy_m, tx_busy_m});
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    check_all();
    flush_tx_req = 0; flush_rx_req = 0; clr_wr = 0; mask_wr = 0; evt_pulse = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 raw after reset", raw_status, 32'h13);
    chk("R1 mask after reset", mask_rd, 32'h0);
    chk("R1 irq after reset", 32'(irq), 32'h0);
    chk("R1 busy after reset", {30'b0, flush_rx_busy, flush_tx_busy}, 32'h0);
    // R2 R3 R4: fill tx to full, offer more -> R6 overrun
    tx_wr_valid = 1;
    for (int i = 0; i < 19; i++) begin tx_wr_data = 8'(8'h40 + i); tick(); end
    chk("R6 overrun after full pushes", 32'(raw_status[3]), 32'h1);
    chk("R3 tx full", 32'(raw_status[2]), 32'h1);
    // full queue offered while engine pops
    tx_rd_ready = 1; tick(); tx_rd_ready = 0; tick();
    tx_wr_valid = 0;
    // R8 clear overrun
    clr_wr = 1; clr_wdata = 32'hFFFF_FFFF; tick();
    chk("R8 overrun cleared", 32'(raw_status[3]), 32'h0);
    chk("R8 level kept", 32'(raw_status[2]), 32'h1);
    // drain tx, check order through model
    tx_rd_ready = 1;
    for (int i = 0; i < 18; i++) tick();
    tx_rd_ready = 0;
    // R5 rx fill with threshold 4
    rx_wr_valid = 1;
    for (int i = 0; i < 6; i++) begin rx_wr_data = 8'(8'hA0 + i); tick(); end
    rx_wr_valid = 0;
    chk("R5 rx near at 6>=4", 32'(raw_status[5]), 32'h1);
    rx_rd_ready = 1; tick(); tick(); tick(); rx_rd_ready = 0; tick();
    chk("R5 rx near at 3<4", 32'(raw_status[5]), 32'h0);
    // R4 thresholds at 0 and 15
    tx_thr = 0; tick();
    chk("R4 thr 0 empty", 32'(raw_status[1]), 32'h1);
    tx_thr = 15; rx_thr = 15; tick();
    // R7 events, including ignored positions
    evt_pulse = 32'hFFFF_FFFF; tick();
    chk("R7 set mask", raw_status & 32'hECE0_FF80, 32'h0);
    chk("R7 set all events", raw_status & EXT_EVT, EXT_EVT);
    // R8 set wins over clear
    evt_pulse = 32'h0100_0000; clr_wr = 1; clr_wdata = 32'h0100_0000; tick();
    chk("R8 set wins", 32'(raw_status[24]), 32'h1);
    clr_wr = 1; clr_wdata = 32'h0008_0000; tick();
    chk("R8 clear one bit", 32'(raw_status[19]), 32'h0);
    // R9 mask
    mask_wr = 1; mask_wdata = 32'hFFFF_FFFF; tick();
    chk("R9 reserved bits", mask_rd, 32'h1FFF_FFFF);
    clr_wr = 1; clr_wdata = 32'hFFFF_FFFF; mask_wr = 1; mask_wdata = 32'h0100_0000; tick();
    chk("R9 irq low", 32'(irq), 32'h0);
    evt_pulse = 32'h0100_0000; tick();
    chk("R9 irq high", 32'(irq), 32'h1);
    // R10 flush with pushes and a repeated request
    tx_wr_valid = 1;
    for (int i = 0; i < 5; i++) begin tx_wr_data = 8'(i); tick(); end
    flush_tx_req = 1; tick();
    chk("R10 busy", 32'(flush_tx_busy), 32'h1);
    flush_tx_req = 1; tick();
    tick(); tick(); tick();
    chk("R10 flush done empty", 32'(raw_status[0]), 32'h1);
    tx_wr_valid = 0; tick();
    // random phase
    for (int i = 0; i < 4000; i++) begin
      tx_wr_valid = ($urandom_range(0, 2) != 0);
      tx_wr_data  = 8'($urandom);
      tx_rd_ready = ($urandom_range(0, 2) == 0);
      rx_wr_valid = ($urandom_range(0, 1) != 0);
      rx_wr_data  = 8'($urandom);
      rx_rd_ready = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 40) == 0) flush_tx_req = 1;
      if ($urandom_range(0, 40) == 0) flush_rx_req = 1;
      if ($urandom_range(0, 20) == 0) begin clr_wr = 1; clr_wdata = $urandom; end
      if ($urandom_range(0, 30) == 0) begin mask_wr = 1; mask_wdata = $urandom; end
      if ($urandom_range(0, 10) == 0) evt_pulse = $urandom;
      if ($urandom_range(0, 50) == 0) begin tx_thr = 4'($urandom); rx_thr = 4'($urandom); end
      tick();
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule